// File: doc/BRIEF.md
# Closed-Caption Word Read-Out Buffer

This block takes the 16-bit caption word recovered from video line 21, raises a line-21 marker pulse, and on the trailing edge of that pulse moves the word into an output buffer. A host fetches the buffered word through a slow serial port made of an active-low enable pin and a serial clock pin. Both pins arrive asynchronously, so each is synchronised and edge-detected in the system clock domain.

The marker pulse can cover even fields only, or every field. While the host holds its enable low, the buffer contents stay frozen. A word that arrives during that time is parked and moves into the buffer once the enable goes high again. After a read that clocked out at least one bit, the buffer reads back as zeros until a fresh word lands. A host can therefore tell "nothing new" apart from real data.

The read side is a four-state machine:
- **RD_IDLE**: not selected, output off.
- **RD_ARMED**: enable low, no clock fall yet, bit 0 on the line.
- **RD_SHIFT**: at least one fall seen.
- **RD_DRAINED**: all 16 bits delivered, line held at 0.

Transitions:
- IDLE→ARMED on an enable fall.
- ARMED→SHIFT on the first serial-clock fall.
- SHIFT→DRAINED on the fall after the last bit.
- Any non-idle state→IDLE on an enable rise.

Top module: `cc_caption_obuf`

## Requirements
- R1: After reset `line_pulse`, `sdo` and `sdo_oe` are 0 and the buffer holds all zeros, so a first read yields 16 zero bits.
- R2: With `mode_both`=0 the line pulse is raised only while `line21_act`=1 and `field_even`=1; an odd field (`field_even`=0) gives no pulse and no transfer.
- R3: With `mode_both`=1 the line pulse is raised whenever `line21_act`=1, in either field.
- R4: When the line pulse falls, the word that was on `cap_word` during the last pulse cycle moves into the buffer.
- R5: `sdo_oe` is 1 only while the synchronised `host_en_n` is low; it follows the pin within 3 system clocks.
- R6: Bits leave least significant first. Bit 0 is on `sdo` once the enable is low, and each falling edge of `host_sclk` advances to the next bit.
- R7: After 16 serial-clock falls in one enable-low window, `sdo` stays 0 until the enable goes high.
- R8: An enable-low window that saw at least one clock fall consumes the buffer. Reading again before a new transfer yields 16 zero bits.
- R9: An enable-low window with no serial-clock fall does not consume the buffer; the next read returns the same word.
- R10: A word whose line pulse ends while the enable is low does not alter the bits being read. It is transferred when the enable returns high and is returned by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_word | input | 16 | Sliced line-21 caption word |
| line21_act | input | 1 | High while the current line is line 21 with valid data |
| field_even | input | 1 | 1 in even fields, 0 in odd fields |
| mode_both | input | 1 | 0: pulse in even fields only; 1: pulse in both fields |
| host_en_n | input | 1 | Host read enable pin, active low, asynchronous |
| host_sclk | input | 1 | Host serial clock pin, idles high, asynchronous |
| line_pulse | output | 1 | Line-21 marker pulse |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |

## Verification
The assertions assume the following about the inputs:
- The host pins change slowly against the system clock, so every pin edge survives synchronisation and no two serial-clock falls merge.
- `field_even` and `mode_both` are steady while `line21_act` is high.

The stimulus keeps to these assumptions. It holds each pin level for six system clocks, and it changes the field and mode inputs only while `line21_act` is low.

// File: rtl/cc_obuf_pkg.sv
package cc_obuf_pkg;

    // Read-side states of the host port
    typedef enum logic [1:0] {
        RD_IDLE    = 2'd0,
        RD_ARMED   = 2'd1,
        RD_SHIFT   = 2'd2,
        RD_DRAINED = 2'd3
    } rd_state_e;

endpackage

// File: rtl/cc_pin_sync.sv
module cc_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= {(STAGES + 1){RST_VAL}};
        end else begin
            sh_q <= {sh_q[STAGES-1:0], pin};
        end
    end

    assign level = sh_q[STAGES-1];
    assign rise  =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall  = ~sh_q[STAGES-1] &  sh_q[STAGES];

endmodule

// File: rtl/cc_line21_gen.sv
module cc_line21_gen #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cap_word,
    input  logic         line21_act,
    input  logic         field_even,
    input  logic         mode_both,
    output logic         line_pulse,
    output logic         xfer_req,
    output logic [W-1:0] stage_word
);
    logic qual;
    logic pulse_q;
    logic pulse_d1_q;

    // pulse qualifies in even fields, or in every field when mode_both is set
    assign qual = line21_act & (mode_both | field_even);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q    <= 1'b0;
            pulse_d1_q <= 1'b0;
            stage_word <= '0;
        end else begin
            pulse_q    <= qual;
            pulse_d1_q <= pulse_q;
            if (qual) begin
                stage_word <= cap_word;
            end
        end
    end

    assign line_pulse = pulse_q;
    // one-cycle request after the trailing edge of the pulse
    assign xfer_req   = pulse_d1_q & ~pulse_q;

endmodule

// File: rtl/cc_read_fsm.sv
module cc_read_fsm
    import cc_obuf_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_fall,
    input  logic         en_rise,
    input  logic         sclk_fall,
    input  logic [W-1:0] obuf,
    output rd_state_e    state,
    output logic         rd_busy,
    output logic         to_idle,
    output logic         consume,
    output logic         sdo,
    output logic         sdo_oe
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [IW-1:0] LAST = IW'(W - 1);

    rd_state_e     state_q, state_d;
    logic [IW-1:0] idx_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: begin
                if (en_fall) state_d = RD_ARMED;
            end
            RD_ARMED: begin
                if (en_rise)        state_d = RD_IDLE;
                else if (sclk_fall) state_d = (W == 1) ? RD_DRAINED : RD_SHIFT;
            end
            RD_SHIFT: begin
                if (en_rise)                        state_d = RD_IDLE;
                else if (sclk_fall && idx_q == LAST) state_d = RD_DRAINED;
            end
            RD_DRAINED: begin
                if (en_rise) state_d = RD_IDLE;
            end
            default: state_d = RD_IDLE;
        endcase
    end

    // state register and bit pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == RD_IDLE) begin
                idx_q <= '0;
            end else if (sclk_fall && !en_rise && idx_q != LAST &&
                         (state_q == RD_ARMED || state_q == RD_SHIFT)) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        state   = state_q;
        rd_busy = (state_q != RD_IDLE);
        to_idle = (state_q != RD_IDLE) && en_rise;
        consume = en_rise && (state_q == RD_SHIFT || state_q == RD_DRAINED);
        sdo_oe  = (state_q != RD_IDLE);
        unique case (state_q)
            RD_ARMED, RD_SHIFT: sdo = obuf[idx_q];
            default:            sdo = 1'b0;
        endcase
    end

endmodule

// File: rtl/cc_word_store.sv
module cc_word_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xfer_req,
    input  logic [W-1:0] stage_word,
    input  logic         rd_busy,
    input  logic         to_idle,
    input  logic         consume,
    output logic [W-1:0] obuf
);
    logic         pend_q;
    logic [W-1:0] pend_word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obuf        <= '0;
            pend_q      <= 1'b0;
            pend_word_q <= '0;
        end else if (xfer_req && (!rd_busy || to_idle)) begin
            // newest word wins when the port is free or just freeing
            obuf   <= stage_word;
            pend_q <= 1'b0;
        end else if (xfer_req) begin
            pend_q      <= 1'b1;
            pend_word_q <= stage_word;
        end else if (to_idle) begin
            if (pend_q)       obuf <= pend_word_q;
            else if (consume) obuf <= '0;
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cc_caption_obuf.sv
module cc_caption_obuf
    import cc_obuf_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cap_word,
    input  logic         line21_act,
    input  logic         field_even,
    input  logic         mode_both,
    input  logic         host_en_n,
    input  logic         host_sclk,
    output logic         line_pulse,
    output logic         sdo,
    output logic         sdo_oe
);
    localparam int NPINS = 2;

    logic [NPINS-1:0] pin_in, pin_lvl, pin_rise, pin_fall;
    logic             xfer_req, rd_busy, to_idle, consume;
    logic [W-1:0]     stage_word, obuf;
    rd_state_e        rd_state;

    assign pin_in = {host_sclk, host_en_n};

    // both host pins idle high
    for (genvar g = 0; g < NPINS; g++) begin : g_sync
        cc_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_in[g]),
            .level (pin_lvl[g]),
            .rise  (pin_rise[g]),
            .fall  (pin_fall[g])
        );
    end

    cc_line21_gen #(.W(W)) u_l21 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_word   (cap_word),
        .line21_act (line21_act),
        .field_even (field_even),
        .mode_both  (mode_both),
        .line_pulse (line_pulse),
        .xfer_req   (xfer_req),
        .stage_word (stage_word)
    );

    cc_read_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_fall   (pin_fall[0]),
        .en_rise   (pin_rise[0]),
        .sclk_fall (pin_fall[1]),
        .obuf      (obuf),
        .state     (rd_state),
        .rd_busy   (rd_busy),
        .to_idle   (to_idle),
        .consume   (consume),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    cc_word_store #(.W(W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_req   (xfer_req),
        .stage_word (stage_word),
        .rd_busy    (rd_busy),
        .to_idle    (to_idle),
        .consume    (consume),
        .obuf       (obuf)
    );

    logic unused_lvl;
    assign unused_lvl = ^pin_lvl;

endmodule

// File: rtl/cc_caption_obuf_chk.sv
module cc_caption_obuf_chk
    import cc_obuf_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         line21_act,
    input logic         field_even,
    input logic         mode_both,
    input logic         line_pulse,
    input logic         sdo,
    input logic         sdo_oe,
    input logic         xfer_req,
    input logic         rd_busy,
    input rd_state_e    rd_state,
    input logic [W-1:0] obuf
);
    // R2
    even_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse && !$past(mode_both)) |-> $past(field_even && line21_act));

    // R4
    xfer_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (!line_pulse && $past(line_pulse)));

    // R10
    frozen_while_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |=> (!rd_busy || $stable(obuf)));

    // R7
    drained_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state == RD_DRAINED) |-> (!sdo && sdo_oe));

    // R5
    hiz_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_busy |-> (!sdo_oe && !sdo));

endmodule

bind cc_caption_obuf cc_caption_obuf_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line21_act (line21_act),
    .field_even (field_even),
    .mode_both  (mode_both),
    .line_pulse (line_pulse),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .xfer_req   (xfer_req),
    .rd_busy    (rd_busy),
    .rd_state   (rd_state),
    .obuf       (obuf)
);

// File: tb/cc_caption_obuf_tb_top.sv
module cc_caption_obuf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cap_word = '0;
    logic        line21_act = 1'b0;
    logic        field_even = 1'b0;
    logic        mode_both = 1'b0;
    logic        host_en_n = 1'b1;
    logic        host_sclk = 1'b1;
    logic        line_pulse, sdo, sdo_oe;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic  b;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    event smp;

    always #4 clk = ~clk;  // 125 MHz

    cc_caption_obuf dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_word   (cap_word),
        .line21_act (line21_act),
        .field_even (field_even),
        .mode_both  (mode_both),
        .host_en_n  (host_en_n),
        .host_sclk  (host_sclk),
        .line_pulse (line_pulse),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe)
    );

    // monitor: pops expected serial bits and compares
    initial begin
        forever begin
            @(smp);
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL %s: sdo sampled with empty queue (actual %0b expected none)", "R6", sdo);
            end else begin
                exp_t it;
                it = exp_q.pop_front();
                n_cmp++;
                if (sdo !== it.b) begin
                    n_bad++;
                    $display("FAIL %s: sdo actual %0b expected %0b", it.tag, sdo, it.b);
                end
            end
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic sample_bit(input logic e, input string tag);
        exp_t it;
        it.b = e; it.tag = tag;
        exp_q.push_back(it);
        -> smp;
        #1;
    endtask

    task automatic send_word(input logic [15:0] w, input logic even, input logic both,
                             input string tag);
        field_even = even; mode_both = both; cap_word = w;
        wait_cyc(1);
        line21_act = 1'b1;
        wait_cyc(3);
        chk(line_pulse, both | even, tag);
        cap_word = ~w;
        line21_act = 1'b0;
        wait_cyc(4);
        chk(line_pulse, 1'b0, tag);
    endtask

    task automatic rd_open();
        host_en_n = 1'b0;
        wait_cyc(6);
        chk(sdo_oe, 1'b1, "R5 oe on");
    endtask

    task automatic rd_close();
        host_en_n = 1'b1;
        wait_cyc(6);
        chk(sdo_oe, 1'b0, "R5 oe off");
    endtask

    // sample bit index first..first+cnt-1, clocking one fall after each
    task automatic rd_bits(input logic [15:0] w, input int first, input int cnt,
                           input string tag);
        for (int i = 0; i < cnt; i++) begin
            int k;
            k = first + i;
            sample_bit((k < 16) ? w[k] : 1'b0, (k < 16) ? tag : "R7 drained");
            host_sclk = 1'b0; wait_cyc(6);
            host_sclk = 1'b1; wait_cyc(6);
        end
    endtask

    task automatic host_read(input logic [15:0] w, input string tag);
        rd_open();
        rd_bits(w, 0, 17, tag);
        sample_bit(1'b0, "R7 after 17 falls");
        rd_close();
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : driver
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        chk(line_pulse, 1'b0, "R1 pulse");
        chk(sdo_oe, 1'b0, "R1 oe");
        chk(sdo, 1'b0, "R1 sdo");
        host_read(16'h0000, "R1 empty buffer");

        // R2 odd field, even-only mode: no pulse, no transfer
        send_word(16'hBEEF, 1'b0, 1'b0, "R2 odd field");
        host_read(16'h0000, "R2 no transfer");

        // R2/R4/R6 even field
        send_word(16'hA5C3, 1'b1, 1'b0, "R2 even field");
        host_read(16'hA5C3, "R4 R6 word");
        // R8 second read
        host_read(16'h0000, "R8 reread zeros");

        // R3 odd field in both-field mode
        send_word(16'h3C81, 1'b0, 1'b1, "R3 odd field");
        // R9 no clock falls: not consumed
        rd_open();
        sample_bit(1'b1, "R9 bit0");
        rd_close();
        host_read(16'h3C81, "R9 word kept");

        // R10 word arrives during a read
        send_word(16'h0F0F, 1'b1, 1'b1, "R3 even field");
        rd_open();
        rd_bits(16'h0F0F, 0, 3, "R10 old word");
        send_word(16'hF00D, 1'b1, 1'b1, "R3 pending word");
        rd_bits(16'h0F0F, 3, 14, "R10 old word kept");
        rd_close();
        host_read(16'hF00D, "R10 pending word");
        host_read(16'h0000, "R8 after pending");

        wait_cyc(4);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule